// File: doc/BRIEF.md
# Relocatable Index/Data Register Window

This block gives a host processor access to a collection of internal byte registers through only two I/O addresses. The host first writes a selector byte to an index location. It then reads or writes the neighbouring data location, and that access reaches whichever register the selector names. A level input tells the block whether the chip is in configuration mode. Outside configuration mode, the selector reaches a small run-time set: two general-purpose I/O bytes and the watchdog control byte. Inside configuration mode, the selector reaches a full 256-entry configuration space. The watchdog control byte is also part of that space.

The index location can sit at one of four I/O addresses. A two-bit field inside the configuration space chooses which one. Programming that field does not move the window at once. The old address keeps decoding until the configuration-exit pulse arrives, and the stored choice is loaded into the live decoder on that clock edge. The data location is always the index location plus one.

The host side is a plain strobe bus and has no valid/ready handshake. A write is one clock cycle with the write strobe high. A read is answered combinationally while the read strobe is high, so the bus has no back-pressure.

Top module: `regwin_port`

## Requirements
- R1: After reset, the index location is at address 0xEA and the data location at 0xEB. The index register, GP1, GP2 and the watchdog control byte are 0x00. The relocation field (configuration index 0x20, bits [1:0]) holds 2'b11.
- R2: The data location is always the active index address plus one. A read of any other address, or any cycle with the read strobe low, returns 0x00. A write to any other address changes no register.
- R3: A write to the index location loads the 8-bit selector, and a read of the index location returns it. The selector keeps its value across any number of data-location accesses.
- R4: The relocation field encodes 00=0xE0, 01=0xE2, 10=0xE4, 11=0xEA. A new value takes effect only on the clock edge where the configuration-exit pulse is high. Until then, the previous address keeps decoding.
- R5: In run mode, selector 0x01 routes data accesses to GP1 and selector 0x02 routes them to GP2.
- R6: The watchdog control byte is reached at selector 0x03 in run mode and at configuration index 0xF4 in configuration mode. Both paths reach the same storage.
- R7: In configuration mode, every selector value 0x00 to 0xFF reads and writes its own configuration byte through the data location.
- R8: In run mode, any selector outside 0x01 to 0x03 reads back 0xFF through the data location, and writes to it change no register.
- R9: The selector is cleared to 0x00 on the first clock edge after the configuration-mode input changes value.
- R10: Data reads are combinational from the selected register. Writes take effect on the rising clock edge while the write strobe is high, and are not visible before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | Host I/O address |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Host read data (combinational) |
| io_rd | input | 1 | I/O read strobe |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| cfg_mode | input | 1 | High while in configuration mode |
| cfg_exit | input | 1 | One-cycle pulse on leaving configuration mode; applies relocation |
| gp1_out | output | 8 | General-purpose register 1 contents |
| gp2_out | output | 8 | General-purpose register 2 contents |
| wdt_ctrl_out | output | 8 | Watchdog control byte contents |

## Verification
The bench writes and reads back all 256 selector values in each mode. This exposes a design that aliases the run-mode decode onto the configuration space, or one that lets unmapped run-mode selectors write a register instead of reading 0xFF. Each of the four relocation codes is programmed, and the bench confirms that the old address still answers before the exit pulse and only the new one answers after it. An eager relocation would lose the window mid-sequence, and a missing one would leave the window at the old address. The bench also confirms that the run-mode watchdog selector and configuration index 0xF4 share storage, that a mode change clears the selector, and that a data write is invisible until its clock edge.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

  typedef logic [7:0] byte_t;

  // what a data-location access is routed to
  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_GP1,
    TGT_GP2,
    TGT_WDT,
    TGT_CFG
  } tgt_e;

  localparam byte_t RUN_SEL_GP1 = 8'h01;
  localparam byte_t RUN_SEL_GP2 = 8'h02;
  localparam byte_t RUN_SEL_WDT = 8'h03;
  localparam byte_t UNMAPPED_RD = 8'hFF;

  // relocation code to index-location low byte
  function automatic byte_t base_of(input logic [1:0] code);
    case (code)
      2'b00:   base_of = 8'hE0;
      2'b01:   base_of = 8'hE2;
      2'b10:   base_of = 8'hE4;
      default: base_of = 8'hEA;
    endcase
  endfunction

  function automatic tgt_e run_target(input byte_t sel);
    case (sel)
      RUN_SEL_GP1: run_target = TGT_GP1;
      RUN_SEL_GP2: run_target = TGT_GP2;
      RUN_SEL_WDT: run_target = TGT_WDT;
      default:     run_target = TGT_NONE;
    endcase
  endfunction

endpackage

// File: rtl/regwin_decode.sv
module regwin_decode
  import regwin_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] io_addr,
  input  logic          cfg_exit,
  input  logic [1:0]    reloc_pending,
  output logic          hit_idx,
  output logic          hit_data,
  output logic [1:0]    base_sel_q
);

  logic [AW-1:0] idx_addr;
  logic [AW-1:0] data_addr;

  // live relocation choice, loaded only when configuration mode is left
  always_ff @(posedge clk) begin
    if (!rst_n)        base_sel_q <= 2'b11;
    else if (cfg_exit) base_sel_q <= reloc_pending;
  end

  always_comb begin
    idx_addr  = {{(AW-8){1'b0}}, base_of(base_sel_q)};
    data_addr = idx_addr + AW'(1);
    hit_idx   = (io_addr == idx_addr);
    hit_data  = (io_addr == data_addr);
  end

  p_base_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_exit |=> $stable(base_sel_q));

  p_base_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_exit |=> base_sel_q == $past(reloc_pending));

  p_hit_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit_idx, hit_data}));

endmodule

// File: rtl/regwin_index.sv
module regwin_index
  import regwin_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cfg_mode,
  input  logic  idx_we,
  input  byte_t wdata,
  output byte_t idx_q
);

  logic  mode_q;
  logic  mode_chg;

  assign mode_chg = (cfg_mode != mode_q);

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= 1'b0;
    else        mode_q <= cfg_mode;
  end

  // a mode change wins over a same-cycle selector write
  always_ff @(posedge clk) begin
    if (!rst_n)        idx_q <= '0;
    else if (mode_chg) idx_q <= '0;
    else if (idx_we)   idx_q <= wdata;
  end

  p_idx_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> idx_q == 8'h00);

  p_idx_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_chg && !idx_we) |=> $stable(idx_q));

  p_idx_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_chg && idx_we) |=> idx_q == $past(wdata));

endmodule

// File: rtl/regwin_cfgspace.sv
module regwin_cfgspace
  import regwin_pkg::*;
#(
  parameter int    DEPTH     = 256,
  parameter byte_t RELOC_IDX = 8'h20,
  parameter byte_t WDT_IDX   = 8'hF4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  we,
  input  byte_t addr,
  input  byte_t wdata,
  output byte_t rdata,
  output logic [1:0] reloc_pending,
  output byte_t wdt_q
);

  localparam int IW = $clog2(DEPTH);

  byte_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++)
        mem[i] <= (i == int'(RELOC_IDX)) ? 8'h03 : 8'h00;
    end else if (we) begin
      mem[addr[IW-1:0]] <= wdata;
    end
  end

  assign rdata         = mem[addr[IW-1:0]];
  assign reloc_pending = mem[RELOC_IDX[IW-1:0]][1:0];
  assign wdt_q         = mem[WDT_IDX[IW-1:0]];

  p_cfg_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem[$past(addr[IW-1:0])] == $past(wdata));

  p_wdt_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(wdt_q));

endmodule

// File: rtl/regwin_runregs.sv
module regwin_runregs
  import regwin_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  we_gp1,
  input  logic  we_gp2,
  input  byte_t wdata,
  output byte_t gp1_q,
  output byte_t gp2_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gp1_q <= '0;
      gp2_q <= '0;
    end else begin
      if (we_gp1) gp1_q <= wdata;
      if (we_gp2) gp2_q <= wdata;
    end
  end

  p_gp_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({we_gp1, we_gp2}));

  p_gp1_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !we_gp1 |=> $stable(gp1_q));

  p_gp2_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !we_gp2 |=> $stable(gp2_q));

endmodule

// File: rtl/regwin_port.sv
module regwin_port
  import regwin_pkg::*;
#(
  parameter int    AW        = 16,
  parameter int    CFG_DEPTH = 256,
  parameter byte_t RELOC_IDX = 8'h20,
  parameter byte_t WDT_IDX   = 8'hF4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] io_addr,
  input  logic [7:0]    io_wdata,
  output logic [7:0]    io_rdata,
  input  logic          io_rd,
  input  logic          io_wr,
  input  logic          cfg_mode,
  input  logic          cfg_exit,
  output logic [7:0]    gp1_out,
  output logic [7:0]    gp2_out,
  output logic [7:0]    wdt_ctrl_out
);

  logic       hit_idx, hit_data;
  logic [1:0] base_sel_q;
  logic [1:0] reloc_pending;
  byte_t      idx_q;
  byte_t      cfg_rdata;
  byte_t      cfg_addr;
  tgt_e       tgt;
  logic       data_wr;
  logic       cfg_we;

  regwin_decode #(.AW(AW)) u_decode (
    .clk           (clk),
    .rst_n         (rst_n),
    .io_addr       (io_addr),
    .cfg_exit      (cfg_exit),
    .reloc_pending (reloc_pending),
    .hit_idx       (hit_idx),
    .hit_data      (hit_data),
    .base_sel_q    (base_sel_q)
  );

  regwin_index u_index (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_mode (cfg_mode),
    .idx_we   (io_wr && hit_idx),
    .wdata    (io_wdata),
    .idx_q    (idx_q)
  );

  // route the data location by mode and selector
  always_comb begin
    tgt      = cfg_mode ? TGT_CFG : run_target(idx_q);
    data_wr  = io_wr && hit_data;
    cfg_addr = (tgt == TGT_WDT) ? WDT_IDX : idx_q;
    cfg_we   = data_wr && (tgt == TGT_CFG || tgt == TGT_WDT);
  end

  regwin_cfgspace #(
    .DEPTH     (CFG_DEPTH),
    .RELOC_IDX (RELOC_IDX),
    .WDT_IDX   (WDT_IDX)
  ) u_cfg (
    .clk           (clk),
    .rst_n         (rst_n),
    .we            (cfg_we),
    .addr          (cfg_addr),
    .wdata         (io_wdata),
    .rdata         (cfg_rdata),
    .reloc_pending (reloc_pending),
    .wdt_q         (wdt_ctrl_out)
  );

  regwin_runregs u_run (
    .clk    (clk),
    .rst_n  (rst_n),
    .we_gp1 (data_wr && tgt == TGT_GP1),
    .we_gp2 (data_wr && tgt == TGT_GP2),
    .wdata  (io_wdata),
    .gp1_q  (gp1_out),
    .gp2_q  (gp2_out)
  );

  always_comb begin
    io_rdata = 8'h00;
    if (io_rd && hit_idx) begin
      io_rdata = idx_q;
    end else if (io_rd && hit_data) begin
      case (tgt)
        TGT_GP1:          io_rdata = gp1_out;
        TGT_GP2:          io_rdata = gp2_out;
        TGT_WDT, TGT_CFG: io_rdata = cfg_rdata;
        default:          io_rdata = UNMAPPED_RD;
      endcase
    end
  end

  p_unmapped_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && hit_data && !cfg_mode && tgt == TGT_NONE)
      |=> $stable(gp1_out) && $stable(gp2_out) && $stable(wdt_ctrl_out));

  p_idx_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && hit_idx) |-> io_rdata == idx_q);

  p_no_rd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |-> io_rdata == 8'h00);

endmodule

// File: tb/regwin_port_bench.sv
`timescale 1ns/1ps
module regwin_port_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        io_rd = 1'b0;
  logic        io_wr = 1'b0;
  logic        cfg_mode = 1'b0;
  logic        cfg_exit = 1'b0;
  logic [7:0]  gp1_out, gp2_out, wdt_ctrl_out;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] exp_cfg [256];
  logic [7:0] cur_base;
  logic [7:0] e_gp1, e_gp2;

  always #2.5 clk = ~clk;

  regwin_port u_regwin_port (
    .clk (clk), .rst_n (rst_n), .io_addr (io_addr), .io_wdata (io_wdata),
    .io_rdata (io_rdata), .io_rd (io_rd), .io_wr (io_wr),
    .cfg_mode (cfg_mode), .cfg_exit (cfg_exit),
    .gp1_out (gp1_out), .gp2_out (gp2_out), .wdt_ctrl_out (wdt_ctrl_out)
  );

  function automatic logic [7:0] addr_of(input logic [1:0] c);
    return (c == 2'b11) ? 8'hEA : 8'hE0 + {5'd0, c, 1'b0};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = {8'h00, a}; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic io_read(input logic [7:0] a, input string req, input logic [7:0] exp);
    @(negedge clk);
    io_addr = {8'h00, a}; io_rd = 1'b1;
    #1 check(req, io_rdata, exp);
    io_rd = 1'b0;
  endtask

  task automatic enter_cfg();
    @(negedge clk); cfg_mode = 1'b1;
    @(negedge clk);
  endtask

  task automatic leave_cfg();
    @(negedge clk); cfg_mode = 1'b0; cfg_exit = 1'b1;
    @(negedge clk); cfg_exit = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] ev;
    logic [1:0] order [4];
    order[0] = 2'b00; order[1] = 2'b10; order[2] = 2'b01; order[3] = 2'b11;
    for (int i = 0; i < 256; i++) exp_cfg[i] = (i == 8'h20) ? 8'h03 : 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_base = 8'hEA;

    // R1 reset state
    check("R1 gp1", gp1_out, 8'h00);
    check("R1 gp2", gp2_out, 8'h00);
    check("R1 wdt", wdt_ctrl_out, 8'h00);
    io_read(8'hEA, "R1 index at EA", 8'h00);
    io_read(8'hE0, "R2 undecoded E0", 8'h00);
    @(negedge clk); io_addr = 16'h00EA; #1 check("R2 no strobe", io_rdata, 8'h00);

    // R2 write to undecoded address
    io_write(8'hE2, 8'h01);
    io_read(8'hEA, "R2 stray write", 8'h00);

    // R10 write visible only after edge
    io_write(8'hEA, 8'h01);
    @(negedge clk);
    io_addr = 16'h00EB; io_wdata = 8'h77; io_wr = 1'b1;
    #1 check("R10 before edge", gp1_out, 8'h00);
    @(negedge clk); io_wr = 1'b0;
    check("R10 after edge", gp1_out, 8'h77);
    e_gp1 = 8'h77; e_gp2 = 8'h00;

    // run-mode sweep of every selector: R3 R5 R6 R8
    for (int s = 0; s < 256; s++) begin
      ev = 8'(s) ^ 8'hC3;
      io_write(cur_base, 8'(s));
      io_read(cur_base, "R3 index readback", 8'(s));
      io_write(cur_base + 8'd1, ev);
      if (s == 1) begin e_gp1 = ev; io_read(cur_base + 8'd1, "R5 gp1", ev); end
      else if (s == 2) begin e_gp2 = ev; io_read(cur_base + 8'd1, "R5 gp2", ev); end
      else if (s == 3) begin exp_cfg[8'hF4] = ev; io_read(cur_base + 8'd1, "R6 wdt run", ev); end
      else io_read(cur_base + 8'd1, "R8 unmapped reads FF", 8'hFF);
      check("R8 gp1 untouched", gp1_out, e_gp1);
      check("R8 gp2 untouched", gp2_out, e_gp2);
      check("R6 wdt out", wdt_ctrl_out, exp_cfg[8'hF4]);
      io_read(cur_base, "R3 index kept", 8'(s));
    end

    // R9 clear on entry; R6 wdt seen at F4
    enter_cfg();
    io_read(cur_base, "R9 index cleared on entry", 8'h00);
    io_write(cur_base, 8'hF4);
    io_read(cur_base + 8'd1, "R6 wdt via F4", exp_cfg[8'hF4]);

    // R7 configuration space sweep
    for (int s = 0; s < 256; s++) begin
      ev = (s == 8'h20) ? 8'h03 : (8'(s) ^ 8'hA5);
      exp_cfg[s] = ev;
      io_write(cur_base, 8'(s));
      io_write(cur_base + 8'd1, ev);
    end
    for (int s = 0; s < 256; s++) begin
      io_write(cur_base, 8'(s));
      io_read(cur_base + 8'd1, "R7 cfg readback", exp_cfg[s]);
    end
    check("R6 wdt from F4 write", wdt_ctrl_out, exp_cfg[8'hF4]);
    check("R7 gp1 untouched", gp1_out, e_gp1);

    // R4 relocation through each code
    for (int k = 0; k < 4; k++) begin
      logic [7:0] nb;
      nb = addr_of(order[k]);
      io_write(cur_base, 8'h20);
      io_write(cur_base + 8'd1, {6'd0, order[k]});
      io_read(cur_base + 8'd1, "R4 field written", {6'd0, order[k]});
      io_read(cur_base, "R4 old base still decodes", 8'h20);
      if (nb != cur_base) io_read(nb, "R4 new base not yet live", 8'h00);
      leave_cfg();
      if (nb != cur_base) io_read(cur_base, "R4 old base dropped", 8'h00);
      io_read(nb, "R9 index cleared on exit", 8'h00);
      cur_base = nb;
      io_write(cur_base, 8'h02);
      io_write(cur_base + 8'd1, 8'h40 + 8'(k));
      e_gp2 = 8'h40 + 8'(k);
      check("R4 gp2 via relocated window", gp2_out, e_gp2);
      io_read(cur_base + 8'd1, "R2 data at base+1", e_gp2);
      enter_cfg();
    end
    leave_cfg();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule